// File: doc/BRIEF.md
# Multi-Device Reset Configuration Controller

This block brings one device out of power-on or hard reset with a 32-bit configuration word and can turn a core checkstop into a hard reset request. The same logic takes one of two roles. A strap input is sampled when power-on reset is released. If the strap is low, the device becomes the configuration master. The master then reads one word per device from an external configuration memory, eight words in all, and pulls low a per-device select line while it fetches that device's word. In a system, each select line is wired to the strap of one slave. If the strap is high, the device becomes a slave. A slave waits for its strap to fall while hard reset is held and latches the word on the shared data input in that cycle.

The four low bits of the word are the clock mode. They are taken only by the first load after power-on reset. Every later hard reset reloads the remaining bits, including the core-disable bit (bit 4). A one-bit register, the checkstop reset enable, is readable and writable through a small register port. A checkstop while the enable is set holds the hard reset request high for a fixed number of cycles. A disabled core can never have the enable set.

Top module: `rstcfg_ctrl`

## Requirements
- R1: In the first clock after `por_n` goes high, a low `strap_n` makes `is_master` 1; a high `strap_n` makes it 0. The role then holds until the next power-on reset.
- R2: As master, the block reads word addresses 0 to 7 in rising order and holds each address for 4 cycles. While word n (n from 1 to 7) is read, `mem_sel_n[n]` is low and every other select is high. `mem_sel_n[0]` is never low.
- R3: As master, the data on `mem_rdata` in the fourth cycle of the word-0 read becomes the device's own `cfg_word`.
- R4: `hreset_req` is high while `por_n` is low. A master keeps it high for exactly 32 cycles after a fetch starts, then drops it.
- R5: As a slave in reset, the cycle in which `strap_n` falls while `hreset_n` is low latches `mem_rdata` into `cfg_word`, and `hreset_req` goes low on the following cycle.
- R6: A slave that sees `hreset_n` high before it is selected leaves reset with a configuration of zero (clock-mode bits excepted, see R7).
- R7: `cfg_word[3:0]` (clock mode) is loaded only by the first load after power-on reset. Later loads replace bits 31:4 and keep bits 3:0.
- R8: `reg_rdata[0]` is the checkstop reset enable, written from `reg_wdata[0]` when `reg_we` is high. `reg_rdata[31:1]` always reads zero.
- R9: While `cfg_word[4]` (core disable) is 1, the enable reads 0 and writes of 1 have no effect.
- R10: In normal operation, a `chkstop` cycle with the enable set raises `hreset_req` for exactly 16 cycles. With the enable clear, `chkstop` leaves `hreset_req` low.
- R11: When `hreset_n` falls in the same cycle as an enabled `chkstop`, the configuration sequence runs and the checkstop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| hreset_n | input | 1 | Hard reset, active low; its falling edge starts reconfiguration |
| strap_n | input | 1 | Role strap at power-on; select input for a slave |
| chkstop | input | 1 | Core checkstop indication |
| hreset_req | output | 1 | Hard reset request, high while a sequence runs |
| is_master | output | 1 | Role chosen at power-on release |
| cfg_word | output | 32 | Active configuration word |
| mem_addr | output | 3 | Configuration memory word address |
| mem_sel_n | output | 8 | Per-device select lines, active low |
| mem_rdata | input | 32 | Configuration memory data, also slave data input |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
Two events can meet in one cycle: a hard reset edge that starts reconfiguration, and an enabled checkstop that would start the fixed 16-cycle hold. The bench sets the enable, then drives `hreset_n` low and `chkstop` high on the same clock. The scoreboard then has to see a complete 32-cycle fetch, with `hreset_req` high and the right address and select in every cycle. A 16-cycle hold would lose most of those items. The new word in that fetch also sets core disable, so the same run shows the enable forced to zero and the clock-mode bits kept from the power-on load.

// File: rtl/rstcfg_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset configuration controller.
package rstcfg_pkg;
    // Top-level sequence states
    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,   // power-on held or just released
        ST_FETCH = 3'd1,   // master reading configuration words
        ST_WAIT  = 3'd2,   // slave waiting for its select
        ST_RUN   = 3'd3,   // normal operation
        ST_HOLD  = 3'd4    // checkstop-triggered reset hold
    } seq_state_t;
endpackage

// File: rtl/rstcfg_fetch.sv
`timescale 1ns/1ps
// Master fetch engine: reads NDEV words, RD_CYC cycles each, in device order.
// Assumes start arrives only while idle; the address returns to 0 when done.
module rstcfg_fetch #(
    parameter int NDEV   = 8,
    parameter int RD_CYC = 4,
    parameter int W      = 32,
    localparam int AW    = $clog2(NDEV),
    localparam int CW    = $clog2(RD_CYC)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          start,
    input  logic [W-1:0]  rdata,
    output logic [AW-1:0] addr,
    output logic [NDEV-1:0] sel_n,
    output logic          cap_valid,
    output logic [AW-1:0] cap_idx,
    output logic [W-1:0]  cap_word,
    output logic          done
);
    logic          busy;
    logic [AW-1:0] idx;
    logic [CW-1:0] cnt;
    logic          last_beat;

    assign last_beat = busy && (cnt == CW'(RD_CYC - 1));

    // Step the beat counter and the word index through the fetch
    always_ff @(posedge clk) begin
        if (!por_n) begin
            busy <= 1'b0;
            idx  <= '0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            cnt  <= '0;
        end else if (busy) begin
            if (last_beat) begin
                cnt <= '0;
                if (idx == AW'(NDEV - 1)) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign addr      = idx;
    assign cap_valid = last_beat;
    assign cap_idx   = idx;
    assign cap_word  = rdata;
    assign done      = last_beat && (idx == AW'(NDEV - 1));

    // One select line per device; device 0 is the master itself
    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        if (i == 0) begin : g_self
            assign sel_n[i] = 1'b1;
        end else begin : g_peer
            assign sel_n[i] = !(busy && (idx == AW'(i)));
        end
    end
endmodule

// File: rtl/rstcfg_hold.sv
`timescale 1ns/1ps
// Fixed-length hold timer for a checkstop reset.
// Assumes start arrives only while idle; expire marks the final held cycle.
module rstcfg_hold #(
    parameter int HOLD_CYC = 16,
    localparam int CW      = $clog2(HOLD_CYC)
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic expire
);
    logic          running;
    logic [CW-1:0] cnt;

    // Count the held cycles from start
    always_ff @(posedge clk) begin
        if (!por_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (running) begin
            if (cnt == CW'(HOLD_CYC - 1)) running <= 1'b0;
            else                          cnt     <= cnt + 1'b1;
        end
    end

    assign expire = running && (cnt == CW'(HOLD_CYC - 1));
endmodule

// File: rtl/rstcfg_store.sv
`timescale 1ns/1ps
// Holds the active configuration word and the checkstop reset enable.
// Clock-mode bits are taken only by the first load after power-on.
// Core disable overrides the enable, including in the same cycle as a load.
module rstcfg_store #(
    parameter int W        = 32,
    parameter int CLK_BITS = 4,
    parameter int CDIS_BIT = 4
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         reg_we,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] cfg_word,
    output logic         csre
);
    logic         clk_set;
    logic [W-1:0] nxt;
    logic         unused_wbits;

    assign unused_wbits = &{1'b0, reg_wdata[W-1:1]};

    // Next configuration word, keeping clock mode after the first load
    always_comb begin
        nxt = cfg_word;
        if (load) begin
            nxt = load_word;
            if (clk_set) nxt[CLK_BITS-1:0] = cfg_word[CLK_BITS-1:0];
        end
    end

    // Update the word, the clock-mode flag and the enable
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cfg_word <= '0;
            clk_set  <= 1'b0;
            csre     <= 1'b0;
        end else begin
            cfg_word <= nxt;
            if (load) clk_set <= 1'b1;
            csre <= (reg_we ? reg_wdata[0] : csre) & ~nxt[CDIS_BIT];
        end
    end
endmodule

// File: rtl/rstcfg_ctrl.sv
`timescale 1ns/1ps
// Reset configuration controller: picks master or slave at power-on release.
// As master it fetches every device's word; as slave it latches its own word.
// Also turns an enabled checkstop into a fixed-length hard reset request.
// Assumes por_n is synchronous to clk; hreset_n is acted on at its falling edge.
module rstcfg_ctrl
    import rstcfg_pkg::*;
#(
    parameter int NDEV     = 8,
    parameter int RD_CYC   = 4,
    parameter int HOLD_CYC = 16,
    parameter int W        = 32,
    parameter int CLK_BITS = 4,
    parameter int CDIS_BIT = 4,
    localparam int AW      = $clog2(NDEV)
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            hreset_n,
    input  logic            strap_n,
    input  logic            chkstop,
    output logic            hreset_req,
    output logic            is_master,
    output logic [W-1:0]    cfg_word,
    output logic [AW-1:0]   mem_addr,
    output logic [NDEV-1:0] mem_sel_n,
    input  logic [W-1:0]    mem_rdata,
    input  logic            reg_we,
    input  logic [W-1:0]    reg_wdata,
    output logic [W-1:0]    reg_rdata
);
    seq_state_t    state;
    logic          hrst_q, strap_q;
    logic          hrst_fall, sel_fall;
    logic          fetch_start, hold_start, hold_expire;
    logic          cap_valid, fetch_done;
    logic [AW-1:0] cap_idx;
    logic [W-1:0]  cap_word;
    logic          load;
    logic [W-1:0]  load_word;
    logic          csre;

    assign hrst_fall = hrst_q & ~hreset_n;
    assign sel_fall  = strap_q & ~strap_n;

    // Remember the previous reset and strap levels for edge detection
    always_ff @(posedge clk) begin
        if (!por_n) begin
            hrst_q  <= 1'b1;
            strap_q <= 1'b1;
        end else begin
            hrst_q  <= hreset_n;
            strap_q <= strap_n;
        end
    end

    // Decide which engine starts and what gets loaded this cycle
    always_comb begin
        fetch_start = 1'b0;
        hold_start  = 1'b0;
        load        = 1'b0;
        load_word   = '0;
        case (state)
            ST_BOOT:  fetch_start = !strap_n;
            ST_RUN: begin
                if (hrst_fall)          fetch_start = is_master;
                else if (chkstop && csre) hold_start = 1'b1;
            end
            ST_FETCH: begin
                if (cap_valid && cap_idx == '0) begin
                    load      = 1'b1;
                    load_word = cap_word;
                end
            end
            ST_WAIT: begin
                if (sel_fall && !hreset_n) begin
                    load      = 1'b1;
                    load_word = mem_rdata;
                end else if (hreset_n) begin
                    load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Sequence state machine and role capture
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state     <= ST_BOOT;
            is_master <= 1'b0;
        end else begin
            case (state)
                ST_BOOT: begin
                    is_master <= !strap_n;
                    state     <= !strap_n ? ST_FETCH : ST_WAIT;
                end
                ST_RUN: begin
                    if (hrst_fall)       state <= is_master ? ST_FETCH : ST_WAIT;
                    else if (hold_start) state <= ST_HOLD;
                end
                ST_FETCH: if (fetch_done)  state <= ST_RUN;
                ST_WAIT:  if (load)        state <= ST_RUN;
                ST_HOLD:  if (hold_expire) state <= ST_RUN;
                default:  state <= ST_RUN;
            endcase
        end
    end

    assign hreset_req = (state != ST_RUN);
    assign reg_rdata  = {{(W-1){1'b0}}, csre};

    rstcfg_fetch #(.NDEV(NDEV), .RD_CYC(RD_CYC), .W(W)) u_fetch (
        .clk(clk), .por_n(por_n), .start(fetch_start), .rdata(mem_rdata),
        .addr(mem_addr), .sel_n(mem_sel_n), .cap_valid(cap_valid),
        .cap_idx(cap_idx), .cap_word(cap_word), .done(fetch_done)
    );

    rstcfg_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .por_n(por_n), .start(hold_start), .expire(hold_expire)
    );

    rstcfg_store #(.W(W), .CLK_BITS(CLK_BITS), .CDIS_BIT(CDIS_BIT)) u_store (
        .clk(clk), .por_n(por_n), .load(load), .load_word(load_word),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .cfg_word(cfg_word), .csre(csre)
    );
endmodule

// File: rtl/rstcfg_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for rstcfg_ctrl, attached with bind below.
module rstcfg_ctrl_chk #(
    parameter int NDEV = 8,
    parameter int W    = 32,
    localparam int AW  = $clog2(NDEV)
) (
    input logic            clk,
    input logic            por_n,
    input logic            hreset_req,
    input logic            is_master,
    input logic [AW-1:0]   mem_addr,
    input logic [NDEV-1:0] mem_sel_n,
    input logic [W-1:0]    reg_rdata,
    input logic            core_dis
);
    // R2
    self_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
        mem_sel_n[0]);
    // R2
    one_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
        $countones(~mem_sel_n) <= 1);
    // R2
    addr_order_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hreset_req && is_master && mem_addr != $past(mem_addr))
            |-> mem_addr == $past(mem_addr) + 1'b1);
    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[W-1:1] == '0);
    // R9
    cdis_force_chk: assert property (@(posedge clk) disable iff (!por_n)
        core_dis |-> !reg_rdata[0]);
    // R4
    por_req_chk: assert property (@(posedge clk)
        !por_n |=> hreset_req);
endmodule

bind rstcfg_ctrl rstcfg_ctrl_chk #(.NDEV(NDEV), .W(W)) u_chk (
    .clk(clk), .por_n(por_n), .hreset_req(hreset_req), .is_master(is_master),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .reg_rdata(reg_rdata),
    .core_dis(cfg_word[CDIS_BIT])
);

// File: tb/rstcfg_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected fetch beats, a monitor pops them.
module rstcfg_ctrl_bench;
    localparam int NDEV = 8;

    typedef struct packed {
        logic [2:0] addr;
        logic [7:0] sel_n;
    } beat_t;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, hreset_n = 1'b0, strap_n = 1'b0, chkstop = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        hreset_req, is_master;
    logic [31:0] cfg_word, reg_rdata, mem_rdata;
    logic [2:0]  mem_addr;
    logic [7:0]  mem_sel_n;
    logic [31:0] mem [NDEV];

    int checks = 0, errors = 0;
    bit mon_on = 1'b0, finished = 1'b0;
    beat_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign mem_rdata = mem[mem_addr];

    rstcfg_ctrl u_rstcfg_ctrl (
        .clk(clk), .por_n(por_n), .hreset_n(hreset_n), .strap_n(strap_n),
        .chkstop(chkstop), .hreset_req(hreset_req), .is_master(is_master),
        .cfg_word(cfg_word), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Queue the 32 beats a master fetch must produce
    task automatic push_fetch();
        for (int k = 0; k < NDEV * 4; k++) begin
            beat_t b;
            b.addr  = 3'(k / 4);
            b.sel_n = 8'hFF;
            if (k / 4 != 0) b.sel_n[k / 4] = 1'b0;
            exp_q.push_back(b);
        end
    endtask

    // Monitor: compare each fetch beat against the scoreboard
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            beat_t b;
            b = exp_q.pop_front();
            check("R2 addr", 32'(mem_addr), 32'(b.addr));
            check("R2 sel", 32'(mem_sel_n), 32'(b.sel_n));
            check("R4 req during fetch", 32'(hreset_req), 32'd1);
            if (exp_q.size() == 0) mon_on = 1'b0;
        end
    end

    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wait_fetch();
        while (mon_on) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NDEV; i++) mem[i] = 32'h1000_0000 + 32'(i);
        mem[0] = 32'hC0DE_0A63;           // clock mode 3, core enabled
        // Reset state during power-on
        repeat (3) @(negedge clk);
        check("R4 req in por", 32'(hreset_req), 32'd1);
        check("R8 reg reset", reg_rdata, 32'd0);
        check("R3 cfg reset", cfg_word, 32'd0);
        // Master boot fetch
        por_n = 1'b1; push_fetch();
        @(posedge clk); mon_on = 1'b1;
        wait_fetch();
        check("R1 master role", 32'(is_master), 32'd1);
        check("R3 own word", cfg_word, 32'hC0DE_0A63);
        check("R4 req dropped", 32'(hreset_req), 32'd0);
        hreset_n = 1'b1;
        // Register port
        wr_reg(32'hFFFF_FFFF);
        check("R8 enable set, reserved zero", reg_rdata, 32'd1);
        wr_reg(32'h0000_0000);
        check("R8 enable cleared", reg_rdata, 32'd0);
        // Checkstop with enable clear
        @(negedge clk); chkstop = 1'b1;
        @(negedge clk); chkstop = 1'b0;
        begin
            int hi = 0;
            repeat (20) begin if (hreset_req) hi++; @(negedge clk); end
            check("R10 disabled checkstop", 32'(hi), 32'd0);
        end
        // Checkstop with enable set
        wr_reg(32'h1);
        @(negedge clk); chkstop = 1'b1;
        @(negedge clk); chkstop = 1'b0;
        begin
            int hi = 0;
            repeat (40) begin if (hreset_req) hi++; @(negedge clk); end
            check("R10 hold length", 32'(hi), 32'd16);
        end
        // R11: hard reset and checkstop together; new word disables the core
        mem[0] = 32'hBEEF_0A1C;
        @(negedge clk); hreset_n = 1'b0; chkstop = 1'b1; push_fetch();
        @(posedge clk); mon_on = 1'b1;
        @(negedge clk); chkstop = 1'b0; hreset_n = 1'b1;
        wait_fetch();
        check("R11 sequence wins", 32'(hreset_req), 32'd0);
        check("R7 clock mode kept", cfg_word, 32'hBEEF_0A13);
        check("R9 enable forced", reg_rdata, 32'd0);
        wr_reg(32'h1);
        check("R9 write ignored", reg_rdata, 32'd0);
        @(negedge clk); chkstop = 1'b1;
        @(negedge clk); chkstop = 1'b0;
        @(negedge clk);
        check("R10 no reset when forced off", 32'(hreset_req), 32'd0);
        // Slave boot, selected
        por_n = 1'b0; strap_n = 1'b1; hreset_n = 1'b0;
        mem[0] = 32'h5A5A_0027;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 slave role", 32'(is_master), 32'd0);
        check("R5 req while waiting", 32'(hreset_req), 32'd1);
        strap_n = 1'b0;
        @(negedge clk);
        check("R5 latched word", cfg_word, 32'h5A5A_0027);
        check("R5 req dropped", 32'(hreset_req), 32'd0);
        strap_n = 1'b1; hreset_n = 1'b1;
        // Slave hard reset, never selected
        mem[0] = 32'hFFFF_FFF0;
        @(negedge clk); hreset_n = 1'b0;
        @(negedge clk);
        check("R6 req in slave reset", 32'(hreset_req), 32'd1);
        hreset_n = 1'b1;
        @(negedge clk);
        check("R6 zero word, R7 clock kept", cfg_word, 32'h0000_0007);
        check("R6 req dropped", 32'(hreset_req), 32'd0);
        // Slave boot with hard reset already released
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 boot default", cfg_word, 32'd0);
        check("R6 boot req", 32'(hreset_req), 32'd0);
        check("R1 slave again", 32'(is_master), 32'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule